// File: doc/BRIEF.md
# Miscellaneous ALU operation unit

This block decodes and executes one 32-bit instruction group of mixed data-processing operations. It takes the instruction as two 16-bit halfwords and two operand values that the caller has already fetched from the register file. It also takes a byte-wise condition vector for the select operation. The unit is purely combinational. In the same evaluation it checks the fixed encoding bits, decodes two 2-bit selectors and yields one result.

The group covers four kinds of work. The first is signed saturating add and subtract, plain or with the second operand doubled. The second is byte, halfword-byte and bit reversal, including a signed variant for the low halfword. The third is a per-byte select between the operands, and the fourth is a leading-zero count. Any encoding outside the group raises an undefined flag and yields nothing. The register indices are returned so that the caller can write the result back.

Top module: `misc_alu_unit`

## Requirements
- R1: The encoding is valid only when first-halfword bits [15:6] equal 1111101010, second-halfword bits [15:12] equal 1111 and second-halfword bits [7:6] equal 10. Otherwise `undef_o` is 1.
- R2: Selector `op1` is first-halfword bits [5:4] and `op2` is second-halfword bits [5:4]. The defined pairs are all `op1`=00, all `op1`=01, `op1`=10 with `op2`=00, and `op1`=11 with `op2`=00. Every other pair sets `undef_o`.
- R3: `dst_idx_o` always carries second-halfword bits [11:8]. `src_a_idx_o` always carries first-halfword bits [3:0], which names the register that supplies `opnd_a`. `src_b_idx_o` always carries second-halfword bits [3:0], which names the register that supplies `opnd_b`.
- R4: With `op1`=00, `op2`=00 gives b+a and `op2`=10 gives b-a, both signed. A result out of range is clamped to 0x7FFFFFFF or 0x80000000, and `sat_o` is then 1.
- R5: With `op1`=00, `op2`=01 gives b+sat(2a) and `op2`=11 gives b-sat(2a). The doubling saturates first and the add or subtract saturates again. `sat_o` is 1 if either step clamps.
- R6: With `op1`=01 the operation acts on b. `op2`=00 reverses the four bytes. `op2`=01 swaps the two bytes inside each halfword. `op2`=10 reverses all 32 bits. `op2`=11 swaps the two low bytes and sign-extends the 16-bit result from its bit 15.
- R7: With `op1`=10, byte i of the result is byte i of a when `ge_i[i]` is 1, and byte i of b otherwise.
- R8: With `op1`=11, the result is the number of leading zeros of b. It is 32 for zero and 0 when bit 31 is set.
- R9: When `undef_o` is 1, `result_o` is 0 and `sat_o` is 0.
- R10: `sat_o` is 0 for every operation outside the `op1`=00 group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_hi_i | input | 16 | First instruction halfword |
| instr_lo_i | input | 16 | Second instruction halfword |
| opnd_a_i | input | 32 | Value of the register named in the first halfword |
| opnd_b_i | input | 32 | Value of the register named in the second halfword |
| ge_i | input | 4 | Per-byte condition bits for the select operation |
| result_o | output | 32 | Operation result, 0 when undefined |
| dst_idx_o | output | 4 | Destination register index |
| src_a_idx_o | output | 4 | Index of the register supplying `opnd_a_i` |
| src_b_idx_o | output | 4 | Index of the register supplying `opnd_b_i` |
| sat_o | output | 1 | A saturating step clamped |
| undef_o | output | 1 | Encoding is undefined |

## Verification
The bench builds the unit with the default 32-bit data width, which is the only width the instruction encoding gives meaning to. At that width the clamp bounds are reachable, together with the double-clamp case of the doubled forms and the full 0-to-32 range of the zero count. All sixteen selector pairs and every value of the fixed-field nibble and bit pair are swept. Each bit of the first-halfword tag is also flipped in turn.

// File: rtl/misc_alu_pkg.sv
package misc_alu_pkg;

  localparam logic [9:0] HI_TAG = 10'b1111101010;
  localparam logic [3:0] LO_TOP = 4'b1111;
  localparam logic [1:0] LO_MID = 2'b10;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SADD,
    OP_DADD,
    OP_SSUB,
    OP_DSUB,
    OP_REV_WORD,
    OP_REV_HALF,
    OP_REV_BITS,
    OP_REV_SX,
    OP_BYTE_SEL,
    OP_LZ_COUNT
  } misc_op_e;

  function automatic logic op_is_sat(input misc_op_e op);
    return (op == OP_SADD) || (op == OP_DADD) || (op == OP_SSUB) || (op == OP_DSUB);
  endfunction

endpackage

// File: rtl/misc_alu_decode.sv
module misc_alu_decode
  import misc_alu_pkg::*;
(
  input  logic [15:0] hi_i,
  input  logic [15:0] lo_i,
  output misc_op_e    op_o,
  output logic        undef_o
);

  logic [1:0] sel1, sel2;
  logic       tag_ok, fixed_ok, enc_ok;
  misc_op_e   pair_op;

  assign sel1     = hi_i[5:4];
  assign sel2     = lo_i[5:4];
  assign tag_ok   = (hi_i[15:6] == HI_TAG);
  assign fixed_ok = (lo_i[15:12] == LO_TOP) && (lo_i[7:6] == LO_MID);
  assign enc_ok   = tag_ok && fixed_ok;

  always_comb begin
    pair_op = OP_NONE;
    unique case (sel1)
      2'b00: begin
        unique case (sel2)
          2'b00: pair_op = OP_SADD;
          2'b01: pair_op = OP_DADD;
          2'b10: pair_op = OP_SSUB;
          default: pair_op = OP_DSUB;
        endcase
      end
      2'b01: begin
        unique case (sel2)
          2'b00: pair_op = OP_REV_WORD;
          2'b01: pair_op = OP_REV_HALF;
          2'b10: pair_op = OP_REV_BITS;
          default: pair_op = OP_REV_SX;
        endcase
      end
      2'b10: pair_op = (sel2 == 2'b00) ? OP_BYTE_SEL : OP_NONE;
      default: pair_op = (sel2 == 2'b00) ? OP_LZ_COUNT : OP_NONE;
    endcase
  end

  assign op_o    = enc_ok ? pair_op : OP_NONE;
  assign undef_o = (op_o == OP_NONE);

  always_comb begin
    if (lo_i[15:12] != LO_TOP || lo_i[7:6] != LO_MID || hi_i[15:6] != HI_TAG) begin
      assert_bad_fields_R1: assert (undef_o)
        else $error("fixed field violation not flagged");
    end
    if (hi_i[5] && lo_i[5:4] != 2'b00) begin
      assert_bad_pair_R2: assert (undef_o)
        else $error("unallocated selector pair not flagged");
    end
  end

endmodule

// File: rtl/misc_alu_sat.sv
module misc_alu_sat #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         dbl_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  // Returns {clamped, value}
  function automatic logic [W:0] sat_sum(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic         minus);
    logic [W:0] ex, ey, s;
    ex = {x[W-1], x};
    ey = {y[W-1], y};
    s  = minus ? (ex - ey) : (ex + ey);
    if (s[W] != s[W-1]) return {1'b1, (s[W] ? NEG_LIM : POS_LIM)};
    return {1'b0, s[W-1:0]};
  endfunction

  logic [W:0]   dbl_pkt, acc_pkt;
  logic [W-1:0] addend;
  logic         dbl_clip, acc_clip;

  assign dbl_pkt  = sat_sum(a_i, a_i, 1'b0);
  assign dbl_clip = dbl_i & dbl_pkt[W];
  assign addend   = dbl_i ? dbl_pkt[W-1:0] : a_i;
  assign acc_pkt  = sat_sum(b_i, addend, sub_i);
  assign acc_clip = acc_pkt[W];
  assign res_o    = acc_pkt[W-1:0];
  assign sat_o    = dbl_clip | acc_clip;

  always_comb begin
    if (acc_clip) begin
      assert_clamp_bounds_R4: assert (res_o == POS_LIM || res_o == NEG_LIM)
        else $error("clamped result %h not at a limit", res_o);
    end
    if (acc_clip && !dbl_i && !sub_i) begin
      assert_add_sign_R4: assert (a_i[W-1] == b_i[W-1])
        else $error("add overflow with mixed operand signs");
    end
    if (dbl_clip) begin
      assert_double_limit_R5: assert (a_i[W-1] != a_i[W-2])
        else $error("doubling clamped an in-range operand");
    end
  end

endmodule

// File: rtl/misc_alu_perm.sv
module misc_alu_perm #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W/8-1:0] ge_i,
  output logic [W-1:0]   rev_word_o,
  output logic [W-1:0]   rev_half_o,
  output logic [W-1:0]   rev_bits_o,
  output logic [W-1:0]   rev_sx_o,
  output logic [W-1:0]   sel_o
);

  localparam int NB = W / 8;
  localparam int NH = W / 16;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign rev_word_o[8*i +: 8] = b_i[8*(NB-1-i) +: 8];
    assign sel_o[8*i +: 8]      = ge_i[i] ? a_i[8*i +: 8] : b_i[8*i +: 8];
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign rev_half_o[16*h +: 16] = {b_i[16*h +: 8], b_i[16*h+8 +: 8]};
  end

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign rev_bits_o[k] = b_i[W-1-k];
  end

  assign rev_sx_o = {{(W-16){b_i[7]}}, b_i[7:0], b_i[15:8]};

  always_comb begin
    assert_bit_ends_R6: assert (rev_bits_o[0] == b_i[W-1] && rev_bits_o[W-1] == b_i[0])
      else $error("bit reversal end bits misplaced");
    assert_sx_fill_R6: assert (rev_sx_o[W-1] == rev_sx_o[15])
      else $error("sign extension does not follow bit 15");
    if (&ge_i) begin
      assert_sel_all_a_R7: assert (sel_o == a_i)
        else $error("select with all conditions set did not return a");
    end
  end

endmodule

// File: rtl/misc_alu_lzc.sv
module misc_alu_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v_i,
  output logic [CW-1:0] cnt_o
);

  function automatic logic [CW-1:0] lead_zeros(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v[i]) n = CW'(W - 1 - i);
    end
    return n;
  endfunction

  assign cnt_o = lead_zeros(v_i);

  always_comb begin
    assert_count_range_R8: assert (cnt_o <= CW'(W))
      else $error("zero count %0d beyond width", cnt_o);
    if (v_i == '0) begin
      assert_zero_full_R8: assert (cnt_o == CW'(W))
        else $error("zero input gave %0d", cnt_o);
    end
    if (v_i[W-1]) begin
      assert_top_set_R8: assert (cnt_o == '0)
        else $error("top bit set gave %0d", cnt_o);
    end
  end

endmodule

// File: rtl/misc_alu_unit.sv
module misc_alu_unit
  import misc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [15:0]         instr_hi_i,
  input  logic [15:0]         instr_lo_i,
  input  logic [DATA_W-1:0]   opnd_a_i,
  input  logic [DATA_W-1:0]   opnd_b_i,
  input  logic [DATA_W/8-1:0] ge_i,
  output logic [DATA_W-1:0]   result_o,
  output logic [3:0]          dst_idx_o,
  output logic [3:0]          src_a_idx_o,
  output logic [3:0]          src_b_idx_o,
  output logic                sat_o,
  output logic                undef_o
);

  localparam int CW = $clog2(DATA_W + 1);

  misc_op_e          op;
  logic              dec_undef;
  logic              sat_group;
  logic [DATA_W-1:0] sat_res;
  logic              sat_raw;
  logic [DATA_W-1:0] rev_word, rev_half, rev_bits, rev_sx, sel_res;
  logic [CW-1:0]     lz_cnt;

  misc_alu_decode u_decode (
    .hi_i    (instr_hi_i),
    .lo_i    (instr_lo_i),
    .op_o    (op),
    .undef_o (dec_undef)
  );

  misc_alu_sat #(.W(DATA_W)) u_sat (
    .a_i   (opnd_a_i),
    .b_i   (opnd_b_i),
    .dbl_i ((op == OP_DADD) || (op == OP_DSUB)),
    .sub_i ((op == OP_SSUB) || (op == OP_DSUB)),
    .res_o (sat_res),
    .sat_o (sat_raw)
  );

  misc_alu_perm #(.W(DATA_W)) u_perm (
    .a_i        (opnd_a_i),
    .b_i        (opnd_b_i),
    .ge_i       (ge_i),
    .rev_word_o (rev_word),
    .rev_half_o (rev_half),
    .rev_bits_o (rev_bits),
    .rev_sx_o   (rev_sx),
    .sel_o      (sel_res)
  );

  misc_alu_lzc #(.W(DATA_W), .CW(CW)) u_lzc (
    .v_i   (opnd_b_i),
    .cnt_o (lz_cnt)
  );

  assign sat_group = op_is_sat(op);

  always_comb begin
    unique case (op)
      OP_SADD, OP_DADD, OP_SSUB, OP_DSUB: result_o = sat_res;
      OP_REV_WORD: result_o = rev_word;
      OP_REV_HALF: result_o = rev_half;
      OP_REV_BITS: result_o = rev_bits;
      OP_REV_SX:   result_o = rev_sx;
      OP_BYTE_SEL: result_o = sel_res;
      OP_LZ_COUNT: result_o = {{(DATA_W-CW){1'b0}}, lz_cnt};
      default:     result_o = '0;
    endcase
  end

  assign sat_o       = sat_group & sat_raw;
  assign undef_o     = dec_undef;
  assign dst_idx_o   = instr_lo_i[11:8];
  assign src_a_idx_o = instr_hi_i[3:0];
  assign src_b_idx_o = instr_lo_i[3:0];

  always_comb begin
    if (undef_o) begin
      assert_undef_quiet_R9: assert (result_o == '0 && !sat_o)
        else $error("undefined encoding produced output");
    end
    if (sat_o) begin
      assert_flag_scope_R10: assert (!undef_o && instr_hi_i[5:4] == 2'b00)
        else $error("saturation flag outside saturating group");
    end
  end

endmodule

// File: tb/misc_alu_unit_tb_top.sv
module misc_alu_unit_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] hi, lo;
  logic [31:0] a, b;
  logic [3:0]  ge;
  logic [31:0] result;
  logic [3:0]  dst, sa, sb;
  logic        sat, undef;

  misc_alu_unit dut_i (
    .instr_hi_i  (hi),
    .instr_lo_i  (lo),
    .opnd_a_i    (a),
    .opnd_b_i    (b),
    .ge_i        (ge),
    .result_o    (result),
    .dst_idx_o   (dst),
    .src_a_idx_o (sa),
    .src_b_idx_o (sb),
    .sat_o       (sat),
    .undef_o     (undef)
  );

  typedef struct packed {
    logic [31:0] r;
    logic [3:0]  d, ia, ib;
    logic        s, u;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  function automatic bit beyond(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  function automatic logic [31:0] clip(input longint v);
    if (v > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  function automatic exp_t model(input [15:0] h, input [15:0] l,
                                 input [31:0] x, input [31:0] y, input [3:0] g);
    exp_t   e;
    longint xs, ys, dv, t;
    bit     dclip;
    e = '0;
    e.d = l[11:8]; e.ia = h[3:0]; e.ib = l[3:0];
    xs = longint'($signed(x));
    ys = longint'($signed(y));
    if (h[15:6] != 10'h3EA || l[15:12] != 4'hF || l[7:6] != 2'b10) begin
      e.u = 1'b1;
      return e;
    end
    case ({h[5:4], l[5:4]})
      4'b0000: begin t = ys + xs; e.r = clip(t); e.s = beyond(t); end
      4'b0010: begin t = ys - xs; e.r = clip(t); e.s = beyond(t); end
      4'b0001, 4'b0011: begin
        dclip = beyond(2 * xs);
        dv = longint'($signed(clip(2 * xs)));
        t = l[5] ? ys - dv : ys + dv;
        e.r = clip(t); e.s = dclip | beyond(t);
      end
      4'b0100: e.r = {y[7:0], y[15:8], y[23:16], y[31:24]};
      4'b0101: e.r = {y[23:16], y[31:24], y[7:0], y[15:8]};
      4'b0110: for (int i = 0; i < 32; i++) e.r[31-i] = y[i];
      4'b0111: e.r = 32'($signed({y[7:0], y[15:8]}));
      4'b1000: for (int i = 0; i < 4; i++) e.r[8*i +: 8] = g[i] ? x[8*i +: 8] : y[8*i +: 8];
      4'b1100: begin
        e.r = 32;
        for (int i = 31; i >= 0; i--) if (y[i]) begin e.r = 31 - i; break; end
      end
      default: e.u = 1'b1;
    endcase
    return e;
  endfunction

  function automatic logic [15:0] mk_hi(input [1:0] o1, input [3:0] rn);
    return {10'b1111101010, o1, rn};
  endfunction

  function automatic logic [15:0] mk_lo(input [3:0] rd, input [1:0] o2, input [3:0] rm);
    return {4'b1111, rd, 2'b10, o2, rm};
  endfunction

  // Driver: applies one stimulus per cycle and queues its expectation
  task automatic send(input [15:0] h, input [15:0] l, input [31:0] x,
                      input [31:0] y, input [3:0] g, input string tag);
    @(posedge clk);
    hi = h; lo = l; a = x; b = y; ge = g;
    exp_q.push_back(model(h, l, x, y, g));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares half a cycle after each drive
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (result !== e.r || dst !== e.d || sa !== e.ia || sb !== e.ib ||
          sat !== e.s || undef !== e.u) begin
        fails++;
        $display("FAIL %s: got r=%h d=%h a=%h b=%h s=%b u=%b exp r=%h d=%h a=%h b=%h s=%b u=%b",
                 t, result, dst, sa, sb, sat, undef, e.r, e.d, e.ia, e.ib, e.s, e.u);
      end
    end
  end

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  localparam logic [31:0] CORNER [8] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                                         32'h4000_0000, 32'hC000_0000, 32'h0000_0001, 32'h3FFF_FFFF};

  initial begin
    hi = '0; lo = '0; a = '0; b = '0; ge = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;

    // Reset-state / all-zero instruction: undefined and quiet (R1, R9)
    send(16'h0, 16'h0, 32'h1234_5678, 32'h9ABC_DEF0, 4'hF, "R1 zero instr");

    // Selector pair sweep, all 16 combinations (R2, R9)
    for (int p = 0; p < 16; p++)
      send(mk_hi(p[3:2], 4'h3), mk_lo(4'h9, p[1:0], 4'h5), 32'h8000_0001, 32'h00F0_8123, 4'h5,
           "R2 pair sweep");

    // Fixed nibble sweep on every pair (R1)
    for (int n = 0; n < 16; n++)
      for (int p = 0; p < 16; p++)
        send(mk_hi(p[3:2], 4'h1), {n[3:0], 4'h2, 2'b10, p[1:0], 4'h6}, 32'h7000_0000,
             32'h7000_0000, 4'hA, "R1 nibble sweep");

    // Fixed bit pair sweep (R1)
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 16; p++)
        send(mk_hi(p[3:2], 4'h2), {4'hF, 4'h4, m[1:0], p[1:0], 4'h7}, 32'hDEAD_BEEF,
             32'h0000_8000, 4'h3, "R1 bit pair sweep");

    // First-halfword tag, one bit flipped at a time (R1, R9)
    for (int k = 6; k < 16; k++)
      send(mk_hi(2'b01, 4'h0) ^ (16'h1 << k), mk_lo(4'h1, 2'b00, 4'h2), 32'h1, 32'h1122_3344,
           4'h0, "R1 tag flip");

    // Field indices across all values (R3)
    for (int i = 0; i < 16; i++)
      send(mk_hi(2'b11, i[3:0]), mk_lo(4'(15 - i), 2'b00, 4'(i ^ 5)), 32'h0, 32'h0000_00FF,
           4'h0, "R3 index fields");

    // Saturation corners (R4, R5, R10)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int o = 0; o < 4; o++)
          send(mk_hi(2'b00, 4'h8), mk_lo(4'hC, o[1:0], 4'hD), CORNER[i], CORNER[j], 4'h0,
               o[0] ? "R5 doubled corner" : "R4 plain corner");

    // Doubling clamps, then second step stays in range (R5)
    send(mk_hi(2'b00, 4'h0), mk_lo(4'h0, 2'b01, 4'h0), 32'h4000_0000, 32'hFFFF_FFFB, 4'h0,
         "R5 first step only");
    send(mk_hi(2'b00, 4'h0), mk_lo(4'h0, 2'b11, 4'h0), 32'h9000_0000, 32'hF000_0000, 4'h0,
         "R5 sub first step only");

    // Reversals and count: single-bit walks (R6, R8, R10)
    for (int k = 0; k < 32; k++)
      for (int o = 0; o < 4; o++)
        send(mk_hi(2'b01, 4'h0), mk_lo(4'h1, o[1:0], 4'h2), 32'h0, 32'h1 << k, 4'h0,
             "R6 bit walk");
    for (int k = 0; k < 32; k++)
      send(mk_hi(2'b11, 4'h0), mk_lo(4'h1, 2'b00, 4'h2), 32'h0, 32'hFFFF_FFFF >> k, 4'h0,
           "R8 count walk");
    send(mk_hi(2'b11, 4'h0), mk_lo(4'h1, 2'b00, 4'h2), 32'hFFFF_FFFF, 32'h0, 4'h0,
         "R8 zero input");
    send(mk_hi(2'b01, 4'h0), mk_lo(4'h1, 2'b11, 4'h2), 32'h0, 32'h0000_0080, 4'h0,
         "R6 sign extend negative");

    // Byte select over every condition pattern (R7)
    for (int g = 0; g < 16; g++)
      send(mk_hi(2'b10, 4'h4), mk_lo(4'h5, 2'b00, 4'h6), 32'hA1A2_A3A4, 32'hB1B2_B3B4, g[3:0],
           "R7 select pattern");

    // Random operands for every defined operation (R4..R8, R10)
    for (int p = 0; p < 16; p++) begin
      if (p[3] && p[1:0] != 2'b00) continue;
      for (int n = 0; n < 200; n++)
        send(mk_hi(p[3:2], 4'($urandom)), mk_lo(4'($urandom), p[1:0], 4'($urandom)), $urandom,
             $urandom, 4'($urandom), "R4 R5 R6 R7 R8 R10 random");
    end

    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end

endmodule